// File: doc/BRIEF.md
# At-Speed Transition Test Sequencer

This block paces one transition-fault test pattern through the scan logic of a design. It drives the scan-enable line and a single clock-enable that gates the test clock for shift, launch and capture. All chains shift together, so the shift phase lasts as many slow ticks as the longest chain holds. That phase also unloads the response of the previous pattern, so each pattern costs one shift phase plus its at-speed pulses.

The block runs from the fast base clock. Two strobes pace it. `slow_en_i` marks the ticks of the low shift frequency and `fast_en_i` marks the ticks of the functional frequency. Two at-speed styles are offered. In shift-launch mode the final shift pulse launches the transition; scan enable then drops at once and one fast capture pulse follows. In capture-launch mode scan enable is low first, a programmable number of slow dead ticks let it settle, and then two fast pulses launch and capture. A one-cycle done flag closes every pattern.

Top module: `atspd_seq`

## Requirements
- R1: After reset, scan_en_o, tck_en_o and done_o are all 0 and the block waits for start_i.
- R2: After an accepted start, scan_en_o is 1 without a break for the whole shift phase. During that phase tck_en_o pulses exactly N times, and only in cycles where slow_en_i is 1. N is the chain length latched at start.
- R3: A chain length of 0 is treated as 1, so one shift pulse is issued.
- R4: In shift-launch mode (mode_i = 0), scan_en_o is 0 in the cycle after the last shift pulse. The block then waits for one fast tick and issues exactly one fast pulse with scan_en_o at 0. When fast_en_i is held at 1, that capture pulse falls 2 cycles after the last shift pulse.
- R5: In capture-launch mode (mode_i = 1), scan_en_o stays 0 for SETTLE_TICKS slow ticks after the shift phase, counting no tick in which a pulse is issued. Two fast pulses with scan_en_o at 0 follow, the launch and then the capture. When fast_en_i is held at 1, they fall in consecutive cycles.
- R6: Every tck_en_o pulse issued while scan_en_o is 0 falls in a cycle where fast_en_i is 1.
- R7: done_o is 1 for exactly one cycle, the cycle right after the capture pulse. Afterwards the block is idle with all outputs at 0.
- R8: start_i is ignored while a pattern is in progress. mode_i and chain_len_i are sampled only when a start is accepted, so changing them mid-run does not alter the pulse counts of the running pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request one pattern; accepted only when idle |
| mode_i | input | 1 | 0 = shift-launch, 1 = capture-launch |
| chain_len_i | input | LEN_W | Length of the longest scan chain |
| slow_en_i | input | 1 | Strobe marking a slow shift tick |
| fast_en_i | input | 1 | Strobe marking a functional-speed tick |
| scan_en_o | output | 1 | Scan enable to the scan cells |
| tck_en_o | output | 1 | Test clock enable for shift, launch and capture |
| done_o | output | 1 | One-cycle end-of-pattern flag |

## Verification
The shift phase begins on the clock edge that samples start_i, so the first shift pulse can fall in the cycle right after that edge. The bench then records outputs and strobes once per cycle, sampling at the falling edge, and stamps every pulse with its cycle index. The index timing rules are relative to the last shift pulse. Under a continuous fast strobe, the capture pulse in shift-launch mode is due 2 cycles later. In capture-launch mode the launch pulse follows the last of SETTLE_TICKS dead slow ticks by one cycle, and the capture pulse follows the launch pulse by one cycle. done_o is due one cycle after the capture pulse. Where the fast strobe is irregular, only the counts and the lower bounds on the gaps are compared, never exact cycle positions.

// File: rtl/atspd_pkg.sv
package atspd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_SHIFT   = 3'd1,
    ST_SETTLE  = 3'd2,
    ST_LAUNCH  = 3'd3,
    ST_CAPTURE = 3'd4,
    ST_DONE    = 3'd5
  } seq_st_e;

  typedef enum logic {
    AT_LOS = 1'b0,
    AT_LOC = 1'b1
  } at_mode_e;

  // at-speed pulses issued with scan enable low, per pattern
  function automatic int unsigned fast_pulses(at_mode_e m);
    return (m == AT_LOC) ? 2 : 1;
  endfunction

  // total test clock pulses per pattern for a given chain length
  function automatic int unsigned pattern_pulses(int unsigned len, at_mode_e m);
    return ((len == 0) ? 1 : len) + fast_pulses(m);
  endfunction

endpackage

// File: rtl/atspd_dncnt.sv
module atspd_dncnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic [W-1:0] cnt,
  output logic         at_one
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt_q <= '0;
    else if (load)                 cnt_q <= load_val;
    else if (dec && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign cnt    = cnt_q;
  assign at_one = (cnt_q == W'(1));

  AST_CNT_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> cnt_q != '0); // R2

endmodule

// File: rtl/atspd_outdec.sv
module atspd_outdec
  import atspd_pkg::*;
(
  input  seq_st_e st,
  input  logic    slow_en,
  input  logic    fast_en,
  output logic    scan_en,
  output logic    tck_en,
  output logic    done
);

  logic shift_tick;
  logic fast_tick;

  always_comb begin
    shift_tick = (st == ST_SHIFT) && slow_en;
    fast_tick  = ((st == ST_LAUNCH) || (st == ST_CAPTURE)) && fast_en;
    scan_en    = (st == ST_SHIFT);
    tck_en     = shift_tick || fast_tick;
    done       = (st == ST_DONE);
  end

endmodule

// File: rtl/atspd_seq.sv
module atspd_seq
  import atspd_pkg::*;
#(
  parameter int LEN_W        = 8,
  parameter int SETTLE_TICKS = 2,
  localparam int SET_W       = $clog2(SETTLE_TICKS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             mode_i,
  input  logic [LEN_W-1:0] chain_len_i,
  input  logic             slow_en_i,
  input  logic             fast_en_i,
  output logic             scan_en_o,
  output logic             tck_en_o,
  output logic             done_o
);

  function automatic logic [LEN_W-1:0] eff_len(logic [LEN_W-1:0] l);
    return (l == '0) ? LEN_W'(1) : l;
  endfunction

  seq_st_e  st_q, st_d;
  at_mode_e mode_q;

  // named internal events
  logic sh_load, sh_dec, sh_last, shift_end;
  logic set_dec, set_last, settle_end;
  logic launch_fire, capture_fire;
  logic [LEN_W-1:0] sh_cnt;
  logic [SET_W-1:0] set_cnt;
  logic [1:0] fast_cnt_q;

  assign sh_load      = (st_q == ST_IDLE) && start_i;
  assign sh_dec       = (st_q == ST_SHIFT) && slow_en_i;
  assign shift_end    = sh_dec && sh_last;
  assign set_dec      = (st_q == ST_SETTLE) && (mode_q == AT_LOC) && slow_en_i;
  assign settle_end   = (mode_q == AT_LOS) ? ((st_q == ST_SETTLE) && fast_en_i)
                                           : (set_dec && set_last);
  assign launch_fire  = (st_q == ST_LAUNCH) && fast_en_i;
  assign capture_fire = (st_q == ST_CAPTURE) && fast_en_i;

  atspd_dncnt #(.W(LEN_W)) u_shift_cnt (
    .clk(clk), .rst_n(rst_n), .load(sh_load), .load_val(eff_len(chain_len_i)),
    .dec(sh_dec), .cnt(sh_cnt), .at_one(sh_last)
  );

  atspd_dncnt #(.W(SET_W)) u_settle_cnt (
    .clk(clk), .rst_n(rst_n), .load(shift_end), .load_val(SET_W'(SETTLE_TICKS)),
    .dec(set_dec), .cnt(set_cnt), .at_one(set_last)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:    if (sh_load)      st_d = ST_SHIFT;
      ST_SHIFT:   if (shift_end)    st_d = ST_SETTLE;
      ST_SETTLE:  if (settle_end)   st_d = (mode_q == AT_LOS) ? ST_CAPTURE : ST_LAUNCH;
      ST_LAUNCH:  if (launch_fire)  st_d = ST_CAPTURE;
      ST_CAPTURE: if (capture_fire) st_d = ST_DONE;
      ST_DONE:                      st_d = ST_IDLE;
      default:                      st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      mode_q <= AT_LOS;
    end else begin
      st_q <= st_d;
      if (sh_load) mode_q <= at_mode_e'(mode_i);
    end
  end

  atspd_outdec u_outdec (
    .st(st_q), .slow_en(slow_en_i), .fast_en(fast_en_i),
    .scan_en(scan_en_o), .tck_en(tck_en_o), .done(done_o)
  );

  // at-speed pulse tally for the checks below
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        fast_cnt_q <= '0;
    else if (sh_load)                  fast_cnt_q <= '0;
    else if (tck_en_o && !scan_en_o)   fast_cnt_q <= fast_cnt_q + 1'b1;
  end

  AST_SHIFT_ON_SLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (tck_en_o && scan_en_o) |-> slow_en_i); // R2
  AST_FAST_ON_FASTEN: assert property (@(posedge clk) disable iff (!rst_n)
    (tck_en_o && !scan_en_o) |-> fast_en_i); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R7
  AST_DONE_AFTER_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(tck_en_o && !scan_en_o)); // R7
  AST_FAST_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (32'(fast_cnt_q) == fast_pulses(mode_q))); // R4 R5
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE) |=> (mode_q == $past(mode_q))); // R8
  AST_SE_DROP_AFTER_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    shift_end |=> !scan_en_o); // R4

endmodule

// File: tb/atspd_seq_tb.sv
module atspd_seq_tb_top;

  localparam int LEN_W  = 8;
  localparam int SETTLE = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic mode = 1'b0;
  logic [LEN_W-1:0] len = '0;
  logic slow_en = 1'b0;
  logic fast_en = 1'b0;
  logic scan_en, tck_en, done;

  int checks = 0;
  int fails  = 0;
  int slow_div = 1;
  bit fast_alt = 1'b0;

  always #4 clk = ~clk;

  atspd_seq #(.LEN_W(LEN_W), .SETTLE_TICKS(SETTLE)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .mode_i(mode), .chain_len_i(len),
    .slow_en_i(slow_en), .fast_en_i(fast_en),
    .scan_en_o(scan_en), .tck_en_o(tck_en), .done_o(done)
  );

  // strobe generator, updated just after each rising edge
  initial begin
    int dcnt = 0;
    bit tog = 1'b0;
    forever begin
      @(posedge clk);
      #1;
      slow_en = (dcnt == 0);
      dcnt = (dcnt + 1 >= slow_div) ? 0 : dcnt + 1;
      tog = ~tog;
      fast_en = fast_alt ? tog : 1'b1;
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R1..: actual timeout expected finish");
    summary();
    $finish;
  end

  task automatic t_reset();
    @(negedge clk);
    check("R1 scan_en", int'(scan_en), 0);
    check("R1 tck_en", int'(tck_en), 0);
    check("R1 done", int'(done), 0);
  endtask

  // one pattern; dist_at >= 0 pokes start/mode/len mid-run
  task automatic t_run(string name, bit m, int l, int sdiv, bit falt, int dist_at);
    int n_shift = 0, n_fast = 0, bad_gap = 0, dead = 0;
    int last_sh = -1, first_f = -1, second_f = -1, done_at = -1, n_done = 0;
    int exp_len = (l == 0) ? 1 : l;
    bit se_fell = 1'b0;
    slow_div = sdiv;
    fast_alt = falt;
    @(posedge clk); #1;
    start = 1'b1; mode = m; len = LEN_W'(l);
    @(posedge clk); #1;
    start = 1'b0;
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk);
      if (c == dist_at)     begin start = 1'b1; mode = ~m; len = LEN_W'(l + 5); end
      if (c == dist_at + 1) start = 1'b0;
      if (scan_en && se_fell) bad_gap++;
      if (!scan_en && n_shift > 0) se_fell = 1'b1;
      if (tck_en && scan_en) begin
        n_shift++; last_sh = c;
        if (!slow_en) bad_gap++;
      end
      if (!scan_en && n_shift > 0 && first_f < 0 && slow_en && !tck_en) dead++;
      if (tck_en && !scan_en) begin
        n_fast++;
        if (!fast_en) bad_gap++;
        if (first_f < 0) first_f = c; else second_f = c;
      end
      if (done) begin n_done++; done_at = c; break; end
    end
    check({name, " R2 shift pulses"}, n_shift, exp_len);
    check({name, " R2 R6 strobe alignment / unbroken se"}, bad_gap, 0);
    check({name, " R7 done seen"}, n_done, 1);
    if (m == 1'b0) begin
      check({name, " R4 one capture pulse"}, n_fast, 1);
      if (!falt) check({name, " R4 capture 2 cycles after last shift"}, first_f - last_sh, 2);
      else       check({name, " R4 capture after last shift"}, int'(first_f - last_sh >= 2), 1);
      check({name, " R7 done after capture"}, done_at - first_f, 1);
    end else begin
      check({name, " R5 launch+capture pulses"}, n_fast, 2);
      if (!falt) begin
        check({name, " R5 dead slow ticks"}, dead, SETTLE);
        check({name, " R5 launch/capture adjacent"}, second_f - first_f, 1);
      end else begin
        check({name, " R5 dead slow ticks min"}, int'(dead >= SETTLE), 1);
      end
      check({name, " R7 done after capture"}, done_at - second_f, 1);
    end
    // idle afterwards: no pulse, no scan enable, no second done
    begin
      int act = 0;
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);
        act += int'(tck_en) + int'(scan_en) + int'(done);
      end
      check({name, " R7 R8 idle after pattern"}, act, 0);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    t_reset();
    #1 rst_n = 1'b1;
    t_reset();
    t_run("los5",      1'b0, 5, 1, 1'b0, -1);
    t_run("los7div4",  1'b0, 7, 4, 1'b0, -1);
    t_run("loc6",      1'b1, 6, 1, 1'b0, -1);
    t_run("loc3alt",   1'b1, 3, 3, 1'b1, -1);
    t_run("los0 R3",   1'b0, 0, 2, 1'b0, -1);
    t_run("loc1",      1'b1, 1, 1, 1'b0, -1);
    t_run("los4alt",   1'b0, 4, 2, 1'b1, -1);
    t_run("busy R8",   1'b0, 4, 2, 1'b0, 2);
    t_run("busyloc R8", 1'b1, 3, 1, 1'b0, 1);
    summary();
    $finish;
  end

endmodule